// File: doc/BRIEF.md
# Synchronous Decade Counter with Per-Bit Toggle Logic

This block counts enabled clock edges in binary-coded decimal, stepping through 0 to 9 and then starting over at 0. The state is held in four toggle flip-flops that share one clock. Each flip-flop flips when a small product term on the present state is true. There is no adder and no compare-and-clear path. The wrap from 9 to 0 comes from the toggle terms themselves, so the pattern 1010 is never produced from a valid count.

A synchronous clear returns the count to zero and wins over the count enable. A terminal flag marks the last digit while counting is enabled, so that a following stage can use it. An active-low asynchronous reset puts the block in a known state at power-up. If the state is ever corrupted into one of the six unused codes, the same toggle terms bring it back into the 0–9 range within two enabled clocks.

Top module: `decade_tff_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and tc_o is 0 (with en_i low); the reset acts without a clock edge.
- R2: On a clock edge with en_i high and clr_i low, a count of 0 to 8 advances by exactly one.
- R3: On a clock edge with en_i high and clr_i low, a count of 9 becomes 0; code 10 (binary 1010) never follows a valid count.
- R4: The state changes only by per-bit toggles: bit 0 on every enabled edge, bit 1 when bit0=1 and bit3=0, bit 2 when bit0=1 and bit1=1, bit 3 when bits 0,1,2 are all 1 or when bit0=1 and bit3=1.
- R5: On a clock edge with en_i low and clr_i low, count_o keeps its value.
- R6: On a clock edge with clr_i high, count_o becomes 0, whatever the value of en_i.
- R7: tc_o is high exactly when count_o equals 9 and en_i is high, with no clock delay.
- R8: From an unused code, enabled edges give 10→11, 11→6, 12→13, 13→4, 14→15, 15→2, so a valid count is reached within two enabled edges.
- R9: Ten consecutive enabled edges starting from 0 visit each of the codes 0 to 9 exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all four state bits |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to zero, takes priority over en_i |
| en_i | input | 1 | Count enable |
| count_o | output | 4 | Present BCD digit |
| tc_o | output | 1 | Terminal flag: digit is 9 and enable is high |

## Verification
Any corrupted state bit appears on count_o in the same cycle, because the output is the flip-flop state itself. One enabled edge later it shows up as a step that is not +1, or as a missing wrap at 9. If a toggle term is wrong, the error hides until the counter reaches the code where that term matters. That can take up to nine enabled edges from zero. For this reason the bench follows a full decade and also sets each unused code directly and checks the exact successor the toggle terms give. A stuck terminal flag appears only at the digit 9, so it is checked with enable both high and low.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned LAST_VAL = 9;
  localparam int unsigned NUM_VAL  = LAST_VAL + 1;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/decade_toggle_terms.sv
// Per-bit toggle conditions for a 0..9 sequence; 9 folds to 0 by itself.
module decade_toggle_terms
  import decade_pkg::*;
(
  input  digit_t state_i,
  output digit_t tgl_o
);
  always_comb begin
    tgl_o[0] = 1'b1;
    tgl_o[1] = state_i[0] & ~state_i[3];
    tgl_o[2] = state_i[0] & state_i[1];
    tgl_o[3] = (state_i[0] & state_i[1] & state_i[2]) | (state_i[0] & state_i[3]);
  end
endmodule

// File: rtl/tff_cell.sv
module tff_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgl_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (clr_i) q_q <= 1'b0;
    else if (tgl_i) q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/decade_tff_counter.sv
module decade_tff_counter
  import decade_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  output logic [DIGIT_W-1:0] count_o,
  output logic               tc_o
);
  digit_t state;
  digit_t tgl_term;

  decade_toggle_terms u_terms (
    .state_i (state),
    .tgl_o   (tgl_term)
  );

  for (genvar b = 0; b < DIGIT_W; b++) begin : gen_bit
    tff_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .tgl_i  (en_i & tgl_term[b]),
      .q_o    (state[b])
    );
  end

  assign count_o = state;
  assign tc_o    = en_i & (state == digit_t'(LAST_VAL));
endmodule

// File: rtl/decade_tff_counter_chk.sv
module decade_tff_counter_chk
  import decade_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               en_i,
  input logic [DIGIT_W-1:0] count_o,
  input logic               tc_o
);
  // R6
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(count_o));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && count_o < digit_t'(LAST_VAL))
      |=> count_o == digit_t'($past(count_o) + digit_t'(1)));

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && count_o == digit_t'(LAST_VAL)) |=> count_o == '0);

  // R8
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && count_o > digit_t'(LAST_VAL) && count_o[0])
      |=> count_o <= digit_t'(LAST_VAL));

  // R7
  tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (en_i && count_o == digit_t'(LAST_VAL)));
endmodule

bind decade_tff_counter decade_tff_counter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .en_i    (en_i),
  .count_o (count_o),
  .tc_o    (tc_o)
);

// File: tb/decade_tff_counter_tb_top.sv
`timescale 1ns/1ps
module decade_tff_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] count_o;
  logic       tc_o;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  decade_tff_counter dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .en_i    (en_i),
    .count_o (count_o),
    .tc_o    (tc_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0; clr_i = 1'b0;
    tick();
    rst_ni = 1'b1;
  endtask

  // R1: reset values, including async assertion mid-count
  task automatic test_reset();
    do_reset();
    check("R1 count after reset", count_o, 0);
    check("R1 tc after reset", tc_o, 0);
    en_i = 1'b1;
    tick(); tick(); tick();
    check("R2 count before async reset", count_o, 3);
    #1 rst_ni = 1'b0;
    #0.5 check("R1 async clear without edge", count_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1; en_i = 1'b0;
  endtask

  // R2 R3 R9: full decades against modulo-10 model
  task automatic test_sequence();
    int model = 0;
    bit [9:0] seen = '0;
    do_reset();
    en_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      model = (model + 1) % 10;
      if (count_o < 10) seen[count_o] = 1'b1;
      check("R2/R3 modulo-10 step", count_o, model);
    end
    check("R9 all ten codes visited", seen, 10'h3FF);
    for (int i = 0; i < 15; i++) begin
      tick();
      model = (model + 1) % 10;
      check("R3 second pass, no 1010", count_o, model);
    end
    en_i = 1'b0;
  endtask

  // R5: enable low holds
  task automatic test_hold();
    do_reset();
    en_i = 1'b1;
    repeat (6) tick();
    en_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R5 hold with en low", count_o, 6);
    end
    en_i = 1'b1; tick();
    check("R2 resume after hold", count_o, 7);
    en_i = 1'b0;
  endtask

  // R6: clear wins over enable
  task automatic test_clear();
    do_reset();
    en_i = 1'b1;
    repeat (5) tick();
    clr_i = 1'b1;
    tick();
    check("R6 clear with en high", count_o, 0);
    tick();
    check("R6 clear held with en high", count_o, 0);
    en_i = 1'b0;
    repeat (0) tick();
    clr_i = 1'b0; en_i = 1'b1;
    repeat (4) tick();
    clr_i = 1'b1; en_i = 1'b0;
    tick();
    check("R6 clear with en low", count_o, 0);
    clr_i = 1'b0;
  endtask

  // R7: terminal flag only at 9 with enable
  task automatic test_tc();
    do_reset();
    en_i = 1'b1;
    repeat (8) begin
      #0.5 check("R7 tc low below 9", tc_o, 0);
      tick();
    end
    #0.5 check("R7 count at 8 tc low", tc_o, 0);
    tick();
    check("R7 count is 9", count_o, 9);
    #0.5 check("R7 tc high at 9 with en", tc_o, 1);
    en_i = 1'b0;
    #0.5 check("R7 tc low at 9 without en", tc_o, 0);
    en_i = 1'b1;
    tick();
    check("R3 wrap to 0", count_o, 0);
    check("R7 tc low after wrap", tc_o, 0);
    en_i = 1'b0;
  endtask

  function automatic int succ(input int v);
    case (v)
      10: succ = 11; 11: succ = 6; 12: succ = 13;
      13: succ = 4;  14: succ = 15; 15: succ = 2;
      default: succ = (v + 1) % 10;
    endcase
  endfunction

  // R4 R8: inject unused codes, follow toggle-term successors
  task automatic inject(input logic [3:0] v);
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b1; clr_i = 1'b0;
    #0.5;
    force dut_i.gen_bit[0].u_cell.q_q = v[0];
    force dut_i.gen_bit[1].u_cell.q_q = v[1];
    force dut_i.gen_bit[2].u_cell.q_q = v[2];
    force dut_i.gen_bit[3].u_cell.q_q = v[3];
    @(negedge clk_i);
    rst_ni = 1'b1;
    release dut_i.gen_bit[0].u_cell.q_q;
    release dut_i.gen_bit[1].u_cell.q_q;
    release dut_i.gen_bit[2].u_cell.q_q;
    release dut_i.gen_bit[3].u_cell.q_q;
  endtask

  task automatic test_recovery();
    for (int v = 10; v < 16; v++) begin
      int exp1 = succ(v);
      int exp2 = succ(exp1);
      inject(4'(v));
      check("R8 injected code held", count_o, v);
      tick();
      check("R4/R8 first successor", count_o, exp1);
      tick();
      check("R8 valid within two edges", count_o, exp2);
      check("R8 in range", int'(count_o <= 9), 1);
    end
    en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_sequence();
    test_hold();
    test_clear();
    test_tc();
    test_recovery();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule